// File: doc/BRIEF.md
# Interrupt Acceptance and Vector Unit

This block sits beside a small 4-bit processor core. It decides, once per clock, whether the core may take an interrupt. When it may, it states which vector address the core should fetch next. There are three kinds of request: a non-maskable request, a software request that carries a vector number, and fifteen peripheral request lines. The block also holds the interrupt-enable flag and supplies the program counter start value that the core loads out of reset.

After reset the block refuses every request, the non-maskable one included, until software has written both stack pointers. It watches a write strobe for each pointer and remembers each write on its own. Only when both writes have been seen does acceptance open.

An accept is a single-cycle pulse with the vector address valid in the same cycle. The core consumes it at once, so the vector path has no valid/ready pair and cannot apply back-pressure. A requester that wants service holds its request until it sees the matching accept. The only exception is the non-maskable request, which is latched on its rising edge. All other pins are plain control and status.

Top module: `irq_accept_unit`

## Requirements
- R1: `boot_pc` always reads 0x0110.
- R2: Reset has these effects. `ien` reads 0 and `take` reads 0. Both stack-pointer write records are cleared. Any latched non-maskable request is dropped.
- R3: No request of any kind is accepted until a pulse has been seen on `stk1_we` and on `stk2_we` since reset, in either order. One of them alone keeps every request refused. The block counts as armed from the edge after the second strobe.
- R4: A peripheral request is accepted only while `ien` is 1.
- R5: Non-maskable and software requests are accepted whatever the value of `ien`.
- R6: A rising edge on `nmi_req` is latched and stays pending until it is accepted. Its vector is 0x0100. Holding `nmi_req` high yields only one accept.
- R7: Peripheral line n, for n from 1 to 15, is bit n-1 of `per_req`. It is level-sensitive and its vector is 0x0100 + n.
- R8: A software request with `swi_num` = n is accepted only for n from 0x11 to 0x3F, and its vector is 0x0100 + n. Any other number is ignored and produces no accept.
- R9: Fixed priority applies: a pending non-maskable request first, then the software request, then the lowest-numbered active peripheral line. At most one request is accepted per cycle.
- R10: Accepting a non-maskable or a peripheral request clears `ien` at the same edge. Accepting a software request leaves `ien` unchanged.
- R11: `ien_set` sets `ien` and `ien_clr` clears it, one edge later. If both are high, the clear wins. A clear caused by an accept also wins over `ien_set`.
- R12: A request that is eligible in cycle k drives `take` high for exactly the cycle after edge k, with `vec_addr` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stk1_we | input | 1 | Write strobe of the first stack pointer |
| stk2_we | input | 1 | Write strobe of the second stack pointer |
| ien_set | input | 1 | Set the interrupt-enable flag |
| ien_clr | input | 1 | Clear the interrupt-enable flag |
| nmi_req | input | 1 | Non-maskable request, edge-detected |
| per_req | input | 15 | Peripheral request lines; bit n-1 is line n |
| swi_req | input | 1 | Software request, held until accepted |
| swi_num | input | 6 | Software vector number |
| take | output | 1 | Single-cycle accept pulse |
| vec_addr | output | 16 | Vector address of the accepted request |
| ien | output | 1 | Current interrupt-enable flag |
| boot_pc | output | 16 | Program counter start value |

## Verification
The bench keeps all three request kinds active while the block is unarmed and then writes only one stack pointer. It then writes the second one, in both orders, to show that a latched non-maskable edge waits for arming. It raises two peripheral lines together to show that the lowest line wins. It raises a non-maskable edge together with a software request and peripheral lines, and a software request together with a peripheral line, to tell the priority order apart from the effect of the automatic flag clear. It sends software numbers at both range limits and just below the lower one to separate legal from ignored numbers. It also checks that a non-maskable line held high is taken only once.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_SWI  = 2'd2,
    SRC_PER  = 2'd3
  } src_e;
endpackage

// File: rtl/arm_tracker.sv
module arm_tracker #(
  parameter int N_PTR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PTR-1:0] ptr_we,
  output logic             armed
);
  logic [N_PTR-1:0] seen;

  // one sticky record per stack pointer
  for (genvar g = 0; g < N_PTR; g++) begin : g_seen
    always_ff @(posedge clk) begin
      if (!rst_n)         seen[g] <= 1'b0;
      else if (ptr_we[g]) seen[g] <= 1'b1;
    end
  end

  assign armed = &seen;
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic consume,
  output logic pend
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= nmi_in;
      // a fresh edge outranks a consume in the same cycle
      pend <= (pend & ~consume) | (nmi_in & ~prev);
    end
  end
endmodule

// File: rtl/req_pick.sv
module req_pick
  import irq_acc_pkg::*;
#(
  parameter int N_PER  = 15,
  parameter int OFS_W  = 6,
  parameter int SWI_LO = 17,
  parameter int SWI_HI = 63
) (
  input  logic             armed,
  input  logic             ien,
  input  logic             nmi_pend,
  input  logic             swi_req,
  input  logic [OFS_W-1:0] swi_num,
  input  logic [N_PER-1:0] per_req,
  output src_e             src,
  output logic [OFS_W-1:0] ofs
);
  logic             per_hit;
  logic [OFS_W-1:0] per_idx;
  logic             swi_ok;

  always_comb begin
    per_hit = 1'b0;
    per_idx = '0;
    // scan downward so the lowest active line is left in per_idx
    for (int i = N_PER - 1; i >= 0; i--) begin
      if (per_req[i]) begin
        per_hit = 1'b1;
        per_idx = OFS_W'(i + 1);
      end
    end
  end

  assign swi_ok = swi_req && (int'(swi_num) >= SWI_LO) && (int'(swi_num) <= SWI_HI);

  always_comb begin
    src = SRC_NONE;
    ofs = '0;
    if (armed) begin
      if (nmi_pend) begin
        src = SRC_NMI;
      end else if (swi_ok) begin
        src = SRC_SWI;
        ofs = swi_num;
      end else if (ien && per_hit) begin
        src = SRC_PER;
        ofs = per_idx;
      end
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_acc_pkg::*;
#(
  parameter int          N_PER    = 15,
  parameter int          OFS_W    = 6,
  parameter logic [15:0] VEC_PAGE = 16'h0100,
  parameter int          BOOT_OFS = 16,
  parameter int          SWI_LO   = 17,
  parameter int          SWI_HI   = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stk1_we,
  input  logic             stk2_we,
  input  logic             ien_set,
  input  logic             ien_clr,
  input  logic             nmi_req,
  input  logic [N_PER-1:0] per_req,
  input  logic             swi_req,
  input  logic [OFS_W-1:0] swi_num,
  output logic             take,
  output logic [15:0]      vec_addr,
  output logic             ien,
  output logic [15:0]      boot_pc
);
  localparam logic [15:0] BOOT_PC = VEC_PAGE + 16'(BOOT_OFS);

  logic             armed;
  logic             nmi_pend;
  src_e             pick;
  logic [OFS_W-1:0] pick_ofs;
  logic             take_q;
  logic [15:0]      vec_q;
  logic             ien_q;
  logic             auto_clr;

  arm_tracker #(.N_PTR(2)) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .ptr_we ({stk2_we, stk1_we}),
    .armed  (armed)
  );

  nmi_edge u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_in  (nmi_req),
    .consume (pick == SRC_NMI),
    .pend    (nmi_pend)
  );

  req_pick #(
    .N_PER  (N_PER),
    .OFS_W  (OFS_W),
    .SWI_LO (SWI_LO),
    .SWI_HI (SWI_HI)
  ) u_pick (
    .armed    (armed),
    .ien      (ien_q),
    .nmi_pend (nmi_pend),
    .swi_req  (swi_req),
    .swi_num  (swi_num),
    .per_req  (per_req),
    .src      (pick),
    .ofs      (pick_ofs)
  );

  assign auto_clr = (pick == SRC_NMI) || (pick == SRC_PER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= VEC_PAGE;
      ien_q  <= 1'b0;
    end else begin
      take_q <= (pick != SRC_NONE);
      if (pick != SRC_NONE) vec_q <= VEC_PAGE + 16'(pick_ofs);
      if (auto_clr || ien_clr) ien_q <= 1'b0;
      else if (ien_set)        ien_q <= 1'b1;
    end
  end

  assign take     = take_q;
  assign vec_addr = vec_q;
  assign ien      = ien_q;
  assign boot_pc  = BOOT_PC;
endmodule

// File: rtl/irq_acc_chk.sv
module irq_acc_chk #(
  parameter logic [15:0] VEC_PAGE = 16'h0100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        take,
  input logic [15:0] vec_addr,
  input logic        ien,
  input logic        armed,
  input logic        nmi_pend
);
  a_r3_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(armed));

  a_r4_per_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr > VEC_PAGE && vec_addr <= VEC_PAGE + 16'd15) |-> $past(ien));

  a_r6_nmi_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == VEC_PAGE) |-> $past(nmi_pend));

  a_r10_ien_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr <= VEC_PAGE + 16'd15) |-> !ien);

  a_r8_swi_window: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr > VEC_PAGE + 16'd15) |->
      (vec_addr >= VEC_PAGE + 16'd17 && vec_addr <= VEC_PAGE + 16'd63));
endmodule

bind irq_accept_unit irq_acc_chk #(.VEC_PAGE(VEC_PAGE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .take     (take),
  .vec_addr (vec_addr),
  .ien      (ien),
  .armed    (armed),
  .nmi_pend (nmi_pend)
);

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stk1_we = 1'b0, stk2_we = 1'b0;
  logic        ien_set = 1'b0, ien_clr = 1'b0;
  logic        nmi_req = 1'b0;
  logic [14:0] per_req = '0;
  logic        swi_req = 1'b0;
  logic [5:0]  swi_num = '0;
  logic        take;
  logic [15:0] vec_addr;
  logic        ien;
  logic [15:0] boot_pc;

  int checks = 0;
  int errors = 0;
  int take_cnt = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_accept_unit u0 (
    .clk(clk), .rst_n(rst_n), .stk1_we(stk1_we), .stk2_we(stk2_we),
    .ien_set(ien_set), .ien_clr(ien_clr), .nmi_req(nmi_req),
    .per_req(per_req), .swi_req(swi_req), .swi_num(swi_num),
    .take(take), .vec_addr(vec_addr), .ien(ien), .boot_pc(boot_pc)
  );

  // monitor: pop one expected vector per accept pulse (R12)
  always begin
    @(posedge clk);
    #1;
    if (rst_n && take) begin
      take_cnt++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected accept: actual %h expected none", vec_addr);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (vec_addr !== e) begin
          errors++;
          $display("FAIL %s vector: actual %h expected %h", t, vec_addr, e);
        end
      end
    end
  end

  task automatic push(input logic [15:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wait_left(input int left);
    int t = 0;
    while (exp_q.size() > left && t < 50) begin
      @(negedge clk);
      t++;
    end
    if (exp_q.size() > left) begin
      checks++;
      errors++;
      $display("FAIL %s missing accept: actual none expected %h", tag_q[0], exp_q[0]);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic quiet(input int n, input string t);
    int c0 = take_cnt;
    repeat (n) @(negedge clk);
    checks++;
    if (take_cnt != c0) begin
      errors++;
      $display("FAIL %s accepts in quiet window: actual %0d expected 0", t, take_cnt - c0);
    end
  endtask

  task automatic pulse_set();
    ien_set = 1'b1; @(negedge clk); ien_set = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 R2 reset state
    chk("R1 boot_pc", boot_pc, 16'h0110);
    chk("R2 ien after reset", {15'd0, ien}, 16'd0);
    chk("R2 take after reset", {15'd0, take}, 16'd0);

    // R11 set
    pulse_set();
    chk("R11 ien set", {15'd0, ien}, 16'd1);

    // R3 unarmed: every kind of request refused
    per_req = 15'h0004; nmi_req = 1'b1; swi_req = 1'b1; swi_num = 6'h20;
    quiet(5, "R3 unarmed");
    swi_req = 1'b0; per_req = '0;
    stk1_we = 1'b1; @(negedge clk); stk1_we = 1'b0;
    quiet(4, "R3 one pointer only");

    // R6 latched edge taken once armed
    push(16'h0100, "R6 pending nmi");
    stk2_we = 1'b1; @(negedge clk); stk2_we = 1'b0;
    wait_left(0);
    chk("R10 ien cleared by nmi", {15'd0, ien}, 16'd0);
    quiet(4, "R6 held nmi once");
    nmi_req = 1'b0;

    // R4 peripheral blocked with ien 0, R7 R9 lowest line wins
    per_req = 15'h0104;
    quiet(4, "R4 ien low");
    push(16'h0103, "R7 lowest line");
    pulse_set();
    wait_left(0);
    per_req = '0;
    chk("R10 ien cleared by peripheral", {15'd0, ien}, 16'd0);

    // R10 software leaves ien, R8 upper limit
    pulse_set();
    push(16'h013F, "R8 upper limit");
    swi_num = 6'h3F; swi_req = 1'b1;
    wait_left(0);
    swi_req = 1'b0;
    chk("R10 ien kept by swi", {15'd0, ien}, 16'd1);
    ien_clr = 1'b1; @(negedge clk); ien_clr = 1'b0;

    // R5 software ungated
    push(16'h0125, "R5 swi with ien 0");
    swi_num = 6'h25; swi_req = 1'b1;
    wait_left(0);
    swi_req = 1'b0;

    // R8 illegal numbers ignored, lower limit accepted
    swi_num = 6'h10; swi_req = 1'b1;
    quiet(4, "R8 number 0x10");
    swi_num = 6'h00;
    quiet(3, "R8 number 0x00");
    push(16'h0111, "R8 lower limit");
    swi_num = 6'h11;
    wait_left(0);
    swi_req = 1'b0;

    // R9 nmi over swi over peripheral
    pulse_set();
    nmi_req = 1'b1;
    @(negedge clk);
    push(16'h0100, "R9 nmi first");
    push(16'h0130, "R9 swi second");
    swi_num = 6'h30; swi_req = 1'b1; per_req = 15'h0810;
    wait_left(0);
    swi_req = 1'b0; nmi_req = 1'b0;
    quiet(3, "R4 peripheral after nmi clear");
    pulse_set();
    push(16'h0105, "R7 line 5");
    wait_left(0);
    per_req = '0;

    // R9 swi over peripheral with ien 1
    pulse_set();
    push(16'h0111, "R9 swi before peripheral");
    push(16'h0105, "R9 peripheral after swi");
    swi_num = 6'h11; swi_req = 1'b1; per_req = 15'h0010;
    wait_left(1);
    swi_req = 1'b0;
    wait_left(0);
    per_req = '0;

    // R11 clear wins
    ien_set = 1'b1; ien_clr = 1'b1; @(negedge clk); ien_set = 1'b0; ien_clr = 1'b0;
    chk("R11 clear wins", {15'd0, ien}, 16'd0);

    // R2 R3 reset drops arming; reverse write order
    do_reset();
    chk("R2 ien after second reset", {15'd0, ien}, 16'd0);
    pulse_set();
    nmi_req = 1'b1; per_req = 15'h0001; swi_num = 6'h20; swi_req = 1'b1;
    quiet(5, "R3 rearm needed");
    stk2_we = 1'b1; @(negedge clk); stk2_we = 1'b0;
    quiet(3, "R3 second pointer only");
    push(16'h0100, "R3 nmi after rearm");
    push(16'h0120, "R3 swi after rearm");
    stk1_we = 1'b1; @(negedge clk); stk1_we = 1'b0;
    wait_left(0);
    swi_req = 1'b0;
    quiet(3, "R4 line 1 with ien 0");
    per_req = '0; nmi_req = 1'b0;

    chk("R12 queue empty", 16'(exp_q.size()), 16'd0);
    finish_run();
  end
endmodule